// File: doc/BRIEF.md
# Majority-Vote Asynchronous Serial Receiver

This block turns an oversampled asynchronous serial line into bytes. A sample-rate tick, produced outside the block at 16 or 8 times the bit rate, sets the pace. While enabled, the receiver waits for the line to fall from high to low. It then checks that the start bit is genuine by voting over three samples taken at the centre of the bit. Once the start bit is accepted, its bit-phase counter is aligned to that edge. Every data bit and the stop bit are decided with the same three-sample centre vote.

A frame carries eight data bits, least-significant bit first. When the stop bit has been decided, the byte appears on the data output together with a one-clock valid strobe. A frame-error flag reports whether the stop vote failed. Only the first stop bit is examined. After it the receiver goes straight back to hunting for the next falling edge, so any further stop bits are simply idle line.

A mode input selects 16 samples per bit (normal) or 8 samples per bit (double speed). The serial input passes through a two-flop synchroniser before any edge detection or voting.

Top module: `uart_vote_rx`

## Requirements
- R1: While reset is asserted, and after it is released, data_o is 0x00, valid_o is 0 and frame_err_o is 0, with the receiver idle.
- R2: While rx_en_i is low the line is ignored. A complete frame driven on the line yields no valid_o pulse, and data_o keeps its previous value.
- R3: A falling edge starts a frame only if at least two of the three centre samples of the start bit are low. Otherwise the receiver returns to idle with no valid_o pulse and waits for a new falling edge.
- R4: With dbl_i = 0 a bit period is 16 ticks, and the vote uses samples 8, 9 and 10, counting the tick that sees the falling edge as sample 1.
- R5: With dbl_i = 1 a bit period is 8 ticks, and the vote uses samples 4, 5 and 6.
- R6: Each data bit takes the majority value of its three centre samples, so a single wrong centre sample does not change the received bit.
- R7: Eight data bits are received least-significant bit first, so the first data bit on the line lands in data_o[0].
- R8: The stop bit is decided by the same vote. If fewer than two of its centre samples are high, frame_err_o is 1 for that frame. Otherwise it is 0. The byte is delivered in both cases.
- R9: valid_o is a one-clock pulse issued when the stop vote completes. frame_err_o and data_o change only in that cycle.
- R10: Only the first stop bit is checked. A new start edge that immediately follows a single stop bit is received as the next frame, and the bit timing is realigned for each start bit.
- R11: Samples are counted only in cycles where tick_i is high. Cycles without a tick do not advance the bit timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Sample-rate enable, one pulse per oversample |
| rx_en_i | input | 1 | Receiver enable |
| rxd_i | input | 1 | Serial line, idle high |
| dbl_i | input | 1 | 1 selects 8 samples per bit, 0 selects 16 |
| data_o | output | 8 | Last received byte |
| valid_o | output | 1 | One-clock strobe: new byte and frame-error status |
| frame_err_o | output | 1 | Stop-bit vote failed for the last frame |

## Verification
The receiver is driven with clean frames in both sampling modes and with frames whose start, data or stop bit has one centre sample inverted. The inverted sample shows that the decision is a vote and not a single sample. A short low pulse whose centre samples are high checks that a false start is rejected. A stop bit with only one high centre sample checks the frame-error path. Back-to-back frames with a single stop bit check that the receiver realigns on every start edge. A frame sent while the receiver is disabled checks that the line is ignored and that data_o holds its value. Ticks come every other clock, so any counting on non-tick cycles would shift the vote window and corrupt the bytes.

// File: rtl/uvr_pkg.sv
package uvr_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned SPB_NRM = 16;
  localparam int unsigned SPB_DBL = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/uvr_sync.sv
// Line synchroniser followed by a tick-qualified falling-edge detector.
module uvr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic rxd_i,
  output logic line_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q, chain_d;
  logic              prev_q, prev_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], rxd_i};
    prev_d  = prev_q;
    if (tick_i) prev_d = chain_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= chain_d;
      prev_q  <= prev_d;
    end
  end

  assign line_o = chain_q[STAGES-1];
  assign fall_o = tick_i & prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/uvr_bitclock.sv
// Oversample counter and three-sample centre vote.
module uvr_bitclock #(
  parameter int unsigned SPB_N = 16,
  parameter int unsigned SPB_D = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic restart_i,
  input  logic run_i,
  input  logic dbl_i,
  input  logic line_i,
  output logic vote_valid_o,
  output logic vote_bit_o,
  output logic bit_end_o
);
  localparam int unsigned CW    = $clog2(SPB_N + 1);
  localparam int unsigned MID_N = SPB_N / 2 + 1;
  localparam int unsigned MID_D = SPB_D / 2 + 1;

  logic [CW-1:0] cnt_q, cnt_d, idx, spb, mid;
  logic [1:0]    smp_q, smp_d;

  always_comb begin
    spb = dbl_i ? CW'(SPB_D) : CW'(SPB_N);
    mid = dbl_i ? CW'(MID_D) : CW'(MID_N);
    idx = (cnt_q >= spb) ? CW'(1) : cnt_q + CW'(1);
  end

  always_comb begin
    cnt_d        = cnt_q;
    smp_d        = smp_q;
    vote_valid_o = 1'b0;
    bit_end_o    = 1'b0;
    if (restart_i) begin
      cnt_d = CW'(1);
      smp_d = 2'b00;
    end else if (run_i && tick_i) begin
      cnt_d = idx;
      if (idx == mid - CW'(1)) smp_d[0] = line_i;
      if (idx == mid)          smp_d[1] = line_i;
      if (idx == mid + CW'(1)) vote_valid_o = 1'b1;
      if (idx == spb)          bit_end_o = 1'b1;
    end
  end

  assign vote_bit_o = (smp_q[0] & smp_q[1]) | (smp_q[0] & line_i) |
                      (smp_q[1] & line_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      smp_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      smp_q <= smp_d;
    end
  end
endmodule

// File: rtl/uvr_frame.sv
// Frame sequencer: start check, data shifting, stop check.
module uvr_frame
  import uvr_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_en_i,
  input  logic          fall_i,
  input  logic          vote_valid_i,
  input  logic          vote_bit_i,
  input  logic          bit_end_i,
  output logic          restart_o,
  output logic          run_o,
  output logic [DW-1:0] data_o,
  output logic          valid_o,
  output logic          frame_err_o
);
  localparam int unsigned BW = $clog2(DW);

  rx_state_e     st_q, st_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [DW-1:0] sh_q, sh_d, data_q, data_d;
  logic          valid_d, ferr_q, ferr_d;

  always_comb begin
    st_d      = st_q;
    bit_d     = bit_q;
    sh_d      = sh_q;
    data_d    = data_q;
    ferr_d    = ferr_q;
    valid_d   = 1'b0;
    restart_o = 1'b0;
    if (!rx_en_i) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: if (fall_i) begin
          st_d      = ST_START;
          restart_o = 1'b1;
        end
        ST_START: begin
          if (vote_valid_i && vote_bit_i) st_d = ST_IDLE;
          else if (bit_end_i) begin
            st_d  = ST_DATA;
            bit_d = '0;
          end
        end
        ST_DATA: begin
          if (vote_valid_i) sh_d = {vote_bit_i, sh_q[DW-1:1]};
          if (bit_end_i) begin
            if (bit_q == BW'(DW - 1)) st_d = ST_STOP;
            else bit_d = bit_q + BW'(1);
          end
        end
        ST_STOP: if (vote_valid_i) begin
          data_d  = sh_q;
          ferr_d  = ~vote_bit_i;
          valid_d = 1'b1;
          st_d    = ST_IDLE;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  assign run_o = (st_q != ST_IDLE) && rx_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      bit_q   <= '0;
      sh_q    <= '0;
      data_q  <= '0;
      ferr_q  <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      st_q    <= st_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      data_q  <= data_d;
      ferr_q  <= ferr_d;
      valid_o <= valid_d;
    end
  end

  assign data_o      = data_q;
  assign frame_err_o = ferr_q;
endmodule

// File: rtl/uart_vote_rx.sv
module uart_vote_rx
  import uvr_pkg::*;
#(
  parameter int unsigned DW       = DATA_W,
  parameter int unsigned SPB_N    = SPB_NRM,
  parameter int unsigned SPB_D    = SPB_DBL,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          rx_en_i,
  input  logic          rxd_i,
  input  logic          dbl_i,
  output logic [DW-1:0] data_o,
  output logic          valid_o,
  output logic          frame_err_o
);
  logic line, fall, restart, run, vote_valid, vote_bit, bit_end;

  uvr_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .rxd_i(rxd_i),
    .line_o(line), .fall_o(fall)
  );

  uvr_bitclock #(.SPB_N(SPB_N), .SPB_D(SPB_D)) u_bclk (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .restart_i(restart),
    .run_i(run), .dbl_i(dbl_i), .line_i(line), .vote_valid_o(vote_valid),
    .vote_bit_o(vote_bit), .bit_end_o(bit_end)
  );

  uvr_frame #(.DW(DW)) u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .rx_en_i(rx_en_i), .fall_i(fall),
    .vote_valid_i(vote_valid), .vote_bit_i(vote_bit), .bit_end_i(bit_end),
    .restart_o(restart), .run_o(run), .data_o(data_o), .valid_o(valid_o),
    .frame_err_o(frame_err_o)
  );
endmodule

// File: rtl/uvr_checker.sv
module uvr_checker #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_i,
  input logic          rx_en_i,
  input logic [DW-1:0] data_o,
  input logic          valid_o,
  input logic          frame_err_o
);
  a_r9_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  a_r9_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o));
  a_r9_ferr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(frame_err_o));
  a_r2_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(rx_en_i));
  a_r11_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(tick_i));
endmodule

bind uart_vote_rx uvr_checker #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .rx_en_i(rx_en_i),
  .data_o(data_o), .valid_o(valid_o), .frame_err_o(frame_err_o)
);

// File: tb/uart_vote_rx_tb.sv
module uart_vote_rx_tb;
  logic       clk, rst_n, tick, rx_en, rxd, dbl;
  logic [7:0] data;
  logic       valid, ferr;
  int         n_chk, n_fail;
  logic [8:0] exp_q[$];
  bit         finished;

  uart_vote_rx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rx_en_i(rx_en),
    .rxd_i(rxd), .dbl_i(dbl), .data_o(data), .valid_o(valid),
    .frame_err_o(ferr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // R11: one tick every other clock
  always @(negedge clk) tick <= rst_n ? ~tick : 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic v);
    rxd = v;
    @(posedge clk iff tick);
    @(negedge clk);
  endtask

  // noise: 0 none, 1 start centre, 2 data centre, 3 stop centre
  task automatic send(input logic [7:0] d, input bit stop_ok, input int noise,
                      input int idle);
    int spb = dbl ? 8 : 16;
    int mid = spb / 2 + 1;
    if (rx_en) exp_q.push_back({~stop_ok, d});
    for (int s = 1; s <= spb; s++) step((noise == 1 && s == mid) ? 1'b1 : 1'b0);
    for (int b = 0; b < 8; b++)
      for (int s = 1; s <= spb; s++)
        step((noise == 2 && s == mid - 1 + (b % 3)) ? ~d[b] : d[b]);
    for (int s = 1; s <= spb; s++) begin
      if (stop_ok) step((noise == 3 && s == mid + 1) ? 1'b0 : 1'b1);
      else step((s == mid) ? 1'b1 : 1'b0);
    end
    for (int s = 0; s < idle; s++) step(1'b1);
  endtask

  // monitor: scoreboard compare on every strobe
  always @(negedge clk) begin
    if (rst_n && valid) begin
      if (exp_q.size() == 0) chk("R2/R3 unexpected strobe", 1, 0);
      else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        chk("R6/R7 data", int'(data), int'(e[7:0]));
        chk("R8 frame error", int'(ferr), int'(e[8]));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; finished = 0;
    rst_n = 1'b0; rx_en = 1'b0; rxd = 1'b1; dbl = 1'b0; tick = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 data", int'(data), 0);
    chk("R1 valid", int'(valid), 0);
    chk("R1 ferr", int'(ferr), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 data after release", int'(data), 0);
    rx_en = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b1);
    // R4 normal mode, R7 LSB first
    send(8'hA5, 1, 0, 4);
    send(8'h01, 1, 0, 4);
    // R6 one wrong centre sample per data bit
    send(8'h3C, 1, 2, 4);
    // R3 start accepted 2-of-3, R8 stop noise tolerated
    send(8'hC3, 1, 1, 2);
    send(8'h7E, 1, 3, 2);
    // R8 bad stop
    send(8'h5A, 0, 0, 4);
    // R10 back-to-back frames, single stop bit
    send(8'h12, 1, 0, 0);
    send(8'h34, 1, 0, 0);
    send(8'hFF, 1, 0, 3);
    // R3 false start: low for 3 samples only
    for (int s = 0; s < 3; s++) step(1'b0);
    for (int s = 0; s < 40; s++) step(1'b1);
    chk("R3 false start no strobe", exp_q.size(), 0);
    chk("R3 data held", int'(data), 8'hFF);
    // R2 disabled receiver
    rx_en = 1'b0;
    send(8'h00, 1, 0, 4);
    chk("R2 data held", int'(data), 8'hFF);
    rx_en = 1'b1;
    for (int s = 0; s < 4; s++) step(1'b1);
    // R5 double speed
    dbl = 1'b1;
    send(8'h96, 1, 0, 4);
    send(8'h69, 1, 2, 0);
    send(8'h80, 0, 0, 4);
    for (int s = 0; s < 10; s++) step(1'b1);
    chk("R9 all frames delivered", exp_q.size(), 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule